// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block runs the hardware loop of one vector instruction. Software or the issue stage hands it a vector length, a sub-vector length code and a twin-predication flag, and then pulses `start`. From then on the sequencer produces at most one sub-element operation per clock. Each operation carries a source and a destination group offset, the sub-vector offset inside the group, and the flat element indices that the datapath uses. The sub-vector offset is the inner counter. The group offsets move only when it wraps, or when a predicate bit masks a whole group.

Predicate bits apply to whole groups. A masked group is stepped over in a single cycle and issues nothing. In twin mode the source and destination offsets move independently: a masked source group consumes no destination slot, and a masked destination group consumes no source group. The live offsets appear on the `step_*` outputs after every step, so that a trap handler can save them. A later `start` with those values on the `resume_*` inputs carries on from the same point.

The controller has three states. In IDLE it waits for work. In RUN it steps the counters. FINISH lasts exactly one cycle and raises `done`. The transitions are:
- IDLE to RUN on an accepted `start` that has work to do.
- IDLE to FINISH on a `start` whose length is zero or whose resume offsets are already out of range.
- RUN to FINISH on the step that carries either group offset to the length.
- FINISH to IDLE always.

Top module: `vstep_seq`

## Requirements
- R1: After reset the block is in IDLE. `busy`, `done` and `issue_valid` are 0, and all `step_*` outputs are 0.
- R2: When `start` is accepted with an effective length of 0, the very next cycle is FINISH with `done` high. No operation is issued.
- R3: The code on `cfg_sub_code` gives the sub-vector length S: code 0 means S=1, code 1 means S=2, code 2 means S=3 and code 3 means S=4. Within a group the sub-vector offset counts from 0 to S-1. Each issued index equals its group offset times S plus the sub-vector offset.
- R4: With every predicate bit set and no stall, the block issues one operation per cycle. It issues length × S operations in total, in ascending order of group and then of sub-vector offset.
- R5: A source group whose bit in `src_pred` (bit number = group offset) is 0 takes one cycle. In that cycle nothing is issued, the group is skipped and the sub-vector offset returns to 0.
- R6: With `cfg_twin` set, a masked source group advances only the source offset. A source group that is enabled while its destination group is masked in `dst_pred` advances only the destination offset. An operation is issued only when both groups are enabled.
- R7: With `cfg_twin` clear, the destination offset always equals the source offset, and `dst_pred` and `resume_dst` have no effect.
- R8: The step that brings either group offset to the length ends the loop. The next cycle shows `done` high for exactly one cycle, with `busy` low and all `step_*` outputs at 0. The block is back in IDLE after that.
- R9: While `stall` is high in RUN, nothing is issued and all offsets hold their values.
- R10: `start` loads the offsets from `resume_src`, `resume_dst` and `resume_sub`, and the loop continues from there. If a `resume_sub` value is not below S it is loaded as 0. If a loaded group offset is not below the length, the loop finishes at once, as in R2.
- R11: A `cfg_len` value above 64 is truncated to 64.
- R12: `start` is ignored unless the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop with the current configuration |
| cfg_len | input | 7 | Vector length, truncated to 64 |
| cfg_sub_code | input | 2 | Sub-vector length code (S = code + 1) |
| cfg_twin | input | 1 | Independent source and destination offsets |
| resume_src | input | 6 | Starting source group offset |
| resume_dst | input | 6 | Starting destination group offset (twin mode only) |
| resume_sub | input | 2 | Starting sub-vector offset |
| src_pred | input | 64 | Source predicate, one bit per group |
| dst_pred | input | 64 | Destination predicate, one bit per group (twin mode) |
| stall | input | 1 | Hold all counters, issue nothing |
| busy | output | 1 | Loop in progress (RUN) |
| done | output | 1 | One-cycle completion pulse (FINISH) |
| issue_valid | output | 1 | An operation is issued this cycle |
| issue_src_grp | output | 6 | Source group offset of the operation |
| issue_dst_grp | output | 6 | Destination group offset of the operation |
| issue_sub | output | 2 | Sub-vector offset of the operation |
| issue_src_idx | output | 8 | Source element index |
| issue_dst_idx | output | 8 | Destination element index |
| step_src | output | 6 | Live source offset for save and restore |
| step_dst | output | 6 | Live destination offset for save and restore |
| step_sub | output | 2 | Live sub-vector offset for save and restore |

## Verification
The hardest case to reach is a loop that resumes part-way through a group, in twin mode, with the two offsets out of step. Every path through the predicate logic meets there: source skips, destination skips and sub-vector wraps. The directed tests reach it by loading `resume_*` values that leave the offsets unequal and start the sub-vector offset at a non-zero value. They pair this with interleaved mask patterns, so that source skips, destination skips and group wraps all occur within a few cycles. A reference model in the bench walks the same rules and lists the expected index pairs. Separate runs add periodic stalls, and a `start` pulse in mid-loop, on top of ordinary sequences.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vstep_sub_ctr.sv
// Inner counter: sub-vector offset within the current group.
module vstep_sub_ctr #(
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [SUB_W-1:0] load_val,
    input  logic             step,
    input  logic [SUB_W-1:0] last_val,
    output logic [SUB_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= (cnt == last_val) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vstep_off_ctr.sv
// Outer counter: one group offset (source or destination).
module vstep_off_ctr #(
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [OFF_W-1:0] load_val,
    input  logic             adv,
    output logic [OFF_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vstep_index.sv
// Flat element index = group * (code + 1) + sub, built as a shift-add.
module vstep_index #(
    parameter int OFF_W = 6,
    parameter int SUB_W = 2,
    parameter int IDX_W = 8
) (
    input  logic [OFF_W-1:0] grp,
    input  logic [SUB_W-1:0] sub,
    input  logic [SUB_W-1:0] code,
    output logic [IDX_W-1:0] idx
);
    localparam int NTERM = SUB_W + 1;

    logic [SUB_W:0]   factor;
    logic [IDX_W-1:0] part [NTERM];
    logic [IDX_W-1:0] acc;

    assign factor = (SUB_W+1)'(code) + 1'b1;

    genvar b;
    generate
        for (b = 0; b < NTERM; b++) begin : g_term
            assign part[b] = factor[b] ? (IDX_W'(grp) << b) : '0;
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int t = 0; t < NTERM; t++) begin
            acc = acc + part[t];
        end
        idx = acc + IDX_W'(sub);
    end
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
    import vstep_pkg::*;
#(
    parameter int MAX_VL  = 64,
    parameter int MAX_SUB = 4,
    localparam int LEN_W  = $clog2(MAX_VL + 1),
    localparam int OFF_W  = $clog2(MAX_VL),
    localparam int SUB_W  = $clog2(MAX_SUB),
    localparam int IDX_W  = $clog2(MAX_VL * MAX_SUB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [SUB_W-1:0]  cfg_sub_code,
    input  logic              cfg_twin,
    input  logic [OFF_W-1:0]  resume_src,
    input  logic [OFF_W-1:0]  resume_dst,
    input  logic [SUB_W-1:0]  resume_sub,
    input  logic [MAX_VL-1:0] src_pred,
    input  logic [MAX_VL-1:0] dst_pred,
    input  logic              stall,
    output logic              busy,
    output logic              done,
    output logic              issue_valid,
    output logic [OFF_W-1:0]  issue_src_grp,
    output logic [OFF_W-1:0]  issue_dst_grp,
    output logic [SUB_W-1:0]  issue_sub,
    output logic [IDX_W-1:0]  issue_src_idx,
    output logic [IDX_W-1:0]  issue_dst_idx,
    output logic [OFF_W-1:0]  step_src,
    output logic [OFF_W-1:0]  step_dst,
    output logic [SUB_W-1:0]  step_sub
);
    // channel 0 = source, channel 1 = destination
    localparam int NCH = 2;

    seq_state_e state_q, state_d;

    logic [LEN_W-1:0] len_q;
    logic [SUB_W-1:0] code_q;
    logic             twin_q;

    logic [LEN_W-1:0] len_eff;
    logic [SUB_W-1:0] sub_init;
    logic             start_ok;
    logic             start_empty;

    logic [OFF_W-1:0] off_q    [NCH];
    logic [OFF_W-1:0] off_init [NCH];
    logic             off_adv  [NCH];
    logic             off_end  [NCH];
    logic [IDX_W-1:0] idx      [NCH];
    logic [SUB_W-1:0] sub_q;

    logic src_on, dst_on, running;
    logic sub_step, grp_skip, finish_now, ctr_clear;

    // ---------------- start decode ----------------
    assign start_ok = start && (state_q == ST_IDLE);
    assign len_eff  = (cfg_len > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : cfg_len;
    assign sub_init = (resume_sub > cfg_sub_code) ? '0 : resume_sub;
    assign off_init[0] = resume_src;
    assign off_init[1] = cfg_twin ? resume_dst : resume_src;
    assign start_empty = (len_eff == '0)
                      || (LEN_W'(off_init[0]) >= len_eff)
                      || (LEN_W'(off_init[1]) >= len_eff);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            code_q <= '0;
            twin_q <= 1'b0;
        end else if (start_ok) begin
            len_q  <= len_eff;
            code_q <= cfg_sub_code;
            twin_q <= cfg_twin;
        end
    end

    // ---------------- step decision ----------------
    assign running = (state_q == ST_RUN) && !stall;
    assign src_on  = src_pred[off_q[0]];
    assign dst_on  = twin_q ? dst_pred[off_q[1]] : 1'b1;

    always_comb begin
        sub_step   = 1'b0;
        grp_skip   = 1'b0;
        off_adv[0] = 1'b0;
        off_adv[1] = 1'b0;
        if (running) begin
            if (!src_on) begin
                grp_skip   = 1'b1;
                off_adv[0] = 1'b1;
                off_adv[1] = !twin_q;
            end else if (!dst_on) begin
                grp_skip   = 1'b1;
                off_adv[1] = 1'b1;
            end else begin
                sub_step   = 1'b1;
                off_adv[0] = (sub_q == code_q);
                off_adv[1] = (sub_q == code_q);
            end
        end
    end

    assign finish_now = (off_adv[0] && off_end[0]) || (off_adv[1] && off_end[1]);
    assign ctr_clear  = finish_now || (start_ok && start_empty);

    // ---------------- counters ----------------
    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_chan
            assign off_end[ch] = (LEN_W'(off_q[ch]) + 1'b1) == len_q;

            vstep_off_ctr #(.OFF_W(OFF_W)) u_off (
                .clk      (clk),
                .rst_n    (rst_n),
                .clear    (ctr_clear),
                .load     (start_ok),
                .load_val (off_init[ch]),
                .adv      (off_adv[ch]),
                .cnt      (off_q[ch])
            );

            vstep_index #(.OFF_W(OFF_W), .SUB_W(SUB_W), .IDX_W(IDX_W)) u_idx (
                .grp  (off_q[ch]),
                .sub  (sub_q),
                .code (code_q),
                .idx  (idx[ch])
            );
        end
    endgenerate

    vstep_sub_ctr #(.SUB_W(SUB_W)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctr_clear || grp_skip),
        .load     (start_ok),
        .load_val (sub_init),
        .step     (sub_step),
        .last_val (code_q),
        .cnt      (sub_q)
    );

    // ---------------- state register ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = start_empty ? ST_FINISH : ST_RUN;
            ST_RUN:    if (finish_now) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy          = (state_q == ST_RUN);
        done          = (state_q == ST_FINISH);
        issue_valid   = sub_step;
        issue_src_grp = off_q[0];
        issue_dst_grp = off_q[1];
        issue_sub     = sub_q;
        issue_src_idx = idx[0];
        issue_dst_idx = idx[1];
        step_src      = off_q[0];
        step_dst      = off_q[1];
        step_sub      = sub_q;
    end
endmodule

// File: rtl/vstep_seq_chk.sv
module vstep_seq_chk #(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = 7,
    parameter int OFF_W  = 6,
    parameter int SUB_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              busy,
    input logic              done,
    input logic              issue_valid,
    input logic [OFF_W-1:0]  issue_src_grp,
    input logic [OFF_W-1:0]  issue_dst_grp,
    input logic [OFF_W-1:0]  step_src,
    input logic [OFF_W-1:0]  step_dst,
    input logic [SUB_W-1:0]  step_sub,
    input logic [MAX_VL-1:0] src_pred,
    input logic [MAX_VL-1:0] dst_pred,
    input logic              twin_q,
    input logic [LEN_W-1:0]  len_q,
    input logic [SUB_W-1:0]  code_q
);
    p_issue_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> busy);

    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !issue_valid);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> ($stable(step_src) && $stable(step_dst) && $stable(step_sub)));

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (step_src == '0 && step_dst == '0 && step_sub == '0 && !busy));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_offsets_in_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (LEN_W'(step_src) < len_q && LEN_W'(step_dst) < len_q));

    p_sub_in_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_sub <= code_q));

    p_src_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> src_pred[issue_src_grp]);

    p_dst_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && twin_q) |-> dst_pred[issue_dst_grp]);

    p_lockstep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !twin_q) |-> (step_src == step_dst));
endmodule

bind vstep_seq vstep_seq_chk #(
    .MAX_VL (MAX_VL),
    .LEN_W  (LEN_W),
    .OFF_W  (OFF_W),
    .SUB_W  (SUB_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall         (stall),
    .busy          (busy),
    .done          (done),
    .issue_valid   (issue_valid),
    .issue_src_grp (issue_src_grp),
    .issue_dst_grp (issue_dst_grp),
    .step_src      (step_src),
    .step_dst      (step_dst),
    .step_sub      (step_sub),
    .src_pred      (src_pred),
    .dst_pred      (dst_pred),
    .twin_q        (twin_q),
    .len_q         (len_q),
    .code_q        (code_q)
);

// File: tb/vstep_seq_tb_top.sv
module vstep_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  cfg_len = '0;
    logic [1:0]  cfg_sub_code = '0;
    logic        cfg_twin = 1'b0;
    logic [5:0]  resume_src = '0;
    logic [5:0]  resume_dst = '0;
    logic [1:0]  resume_sub = '0;
    logic [63:0] src_pred = '0;
    logic [63:0] dst_pred = '0;
    logic        stall = 1'b0;
    logic        busy, done, issue_valid;
    logic [5:0]  issue_src_grp, issue_dst_grp;
    logic [1:0]  issue_sub;
    logic [7:0]  issue_src_idx, issue_dst_idx;
    logic [5:0]  step_src, step_dst;
    logic [1:0]  step_sub;

    int checks = 0;
    int failures = 0;
    int exp_s[$], exp_d[$], got_s[$], got_d[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vstep_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_sub_code(cfg_sub_code), .cfg_twin(cfg_twin),
        .resume_src(resume_src), .resume_dst(resume_dst), .resume_sub(resume_sub),
        .src_pred(src_pred), .dst_pred(dst_pred), .stall(stall),
        .busy(busy), .done(done), .issue_valid(issue_valid),
        .issue_src_grp(issue_src_grp), .issue_dst_grp(issue_dst_grp),
        .issue_sub(issue_sub), .issue_src_idx(issue_src_idx),
        .issue_dst_idx(issue_dst_idx), .step_src(step_src),
        .step_dst(step_dst), .step_sub(step_sub)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference walk of the stepping rules; fills exp_s/exp_d, returns step cycles.
    task automatic build_expect(input int len, input int code, input bit twin,
                                input int rs, input int rd, input int rsub,
                                input logic [63:0] sm, input logic [63:0] dm,
                                output int steps);
        int L, S, s, d, u;
        exp_s.delete(); exp_d.delete();
        S = code + 1;
        L = (len > 64) ? 64 : len;
        s = rs;
        d = twin ? rd : rs;
        u = (rsub < S) ? rsub : 0;
        steps = 0;
        if (L == 0 || s >= L || d >= L) return;
        forever begin
            if (!sm[s]) begin
                s++; if (!twin) d++; u = 0;
            end else if (twin && !dm[d]) begin
                d++; u = 0;
            end else begin
                exp_s.push_back(s*S + u);
                exp_d.push_back(d*S + u);
                if (u == S-1) begin u = 0; s++; d++; end
                else u++;
            end
            steps++;
            if (s >= L || d >= L) break;
        end
    endtask

    task automatic run_seq(input string req, input int len, input int code,
                           input bit twin, input int rs, input int rd, input int rsub,
                           input logic [63:0] sm, input logic [63:0] dm,
                           input int stall_mod, input int restart_at);
        int steps, live, k;
        bit seen_done, held;
        int h_s, h_d, h_u;
        build_expect(len, code, twin, rs, rd, rsub, sm, dm, steps);
        got_s.delete(); got_d.delete();
        @(negedge clk);
        cfg_len = 7'(len); cfg_sub_code = 2'(code); cfg_twin = twin;
        resume_src = 6'(rs); resume_dst = 6'(rd); resume_sub = 2'(rsub);
        src_pred = sm; dst_pred = dm; start = 1'b1;
        @(negedge clk);
        k = 0; live = 0; seen_done = 0; held = 0; h_s = 0; h_d = 0; h_u = 0;
        while (!seen_done && k < 2000) begin
            stall = (stall_mod > 0) && (k % stall_mod == 1);
            if (k == restart_at) begin
                start = 1'b1; cfg_len = 7'd2; cfg_twin = ~twin; cfg_sub_code = 2'd0;
                resume_src = '0; resume_dst = '0;
            end else begin
                start = 1'b0;
            end
            #1;
            if (held) begin
                check(step_src == h_s && step_dst == h_d && step_sub == h_u, "R9",
                      "offsets held over stall", int'(step_src), h_s);
                held = 0;
            end
            if (done) begin
                seen_done = 1;
                check(live == steps, req, "step cycles before done", live, steps);
                check(step_src == 0 && step_dst == 0 && step_sub == 0 && !busy, "R8",
                      "cleared at done", int'(step_src) + int'(step_dst) + int'(step_sub), 0);
            end else if (stall) begin
                check(!issue_valid, "R9", "no issue while stalled", int'(issue_valid), 0);
                held = 1; h_s = int'(step_src); h_d = int'(step_dst); h_u = int'(step_sub);
            end else begin
                live++;
                if (issue_valid) begin
                    got_s.push_back(int'(issue_src_idx));
                    got_d.push_back(int'(issue_dst_idx));
                end
            end
            @(negedge clk);
            k++;
        end
        stall = 1'b0; start = 1'b0;
        check(seen_done, req, "done reached", int'(seen_done), 1);
        #1;
        check(!done && !busy, "R8", "done lasts one cycle", int'(done), 0);
        check(got_s.size() == exp_s.size(), req, "issue count", got_s.size(), exp_s.size());
        for (int i = 0; i < exp_s.size() && i < got_s.size(); i++) begin
            check(got_s[i] == exp_s[i], req, $sformatf("src index #%0d", i), got_s[i], exp_s[i]);
            check(got_d[i] == exp_d[i], req, $sformatf("dst index #%0d", i), got_d[i], exp_d[i]);
        end
    endtask

    task automatic t_reset;
        #1;
        check(!busy && !done && !issue_valid, "R1", "idle flags", int'(busy) + int'(done), 0);
        check(step_src == 0 && step_dst == 0 && step_sub == 0, "R1", "zero offsets",
              int'(step_src), 0);
    endtask

    task automatic t_plain;   // R3 R4 R7: dst_pred all zero must not matter
        run_seq("R4", 5, 2, 1'b0, 0, 0, 0, '1, '0, 0, -1);
        run_seq("R7", 4, 1, 1'b0, 1, 3, 0, '1, 64'h5, 0, -1);
    endtask

    task automatic t_sub_codes; // R3
        for (int c = 0; c < 4; c++) run_seq("R3", 3, c, 1'b0, 0, 0, 0, '1, '1, 0, -1);
    endtask

    task automatic t_group_mask; // R5
        run_seq("R5", 7, 1, 1'b0, 0, 0, 0, 64'b1011010, '0, 0, -1);
        run_seq("R5", 8, 3, 1'b0, 0, 0, 0, 64'b0111_1110, '0, 0, -1);
    endtask

    task automatic t_twin; // R6
        run_seq("R6", 6, 1, 1'b1, 0, 0, 0, 64'b110101, 64'b011110, 0, -1);
        run_seq("R6", 9, 2, 1'b1, 2, 4, 1, 64'b1_1010_1100, 64'b1_0111_0101, 0, -1);
    endtask

    task automatic t_zero_len; // R2
        run_seq("R2", 0, 3, 1'b0, 0, 0, 0, '1, '1, 0, -1);
    endtask

    task automatic t_stall; // R9
        run_seq("R9", 4, 3, 1'b0, 0, 0, 0, '1, '1, 3, -1);
        run_seq("R9", 6, 1, 1'b1, 0, 1, 0, 64'b101111, 64'b111011, 2, -1);
    endtask

    task automatic t_resume; // R10
        run_seq("R10", 6, 3, 1'b0, 3, 0, 2, '1, '1, 0, -1);
        run_seq("R10", 7, 1, 1'b1, 2, 4, 1, '1, '1, 0, -1);
        run_seq("R10", 4, 1, 1'b0, 1, 0, 3, '1, '1, 0, -1);
        run_seq("R10", 5, 0, 1'b1, 1, 5, 0, '1, '1, 0, -1);
    endtask

    task automatic t_clamp; // R11
        run_seq("R11", 100, 0, 1'b0, 0, 0, 0, '1, '1, 0, -1);
        run_seq("R11", 64, 3, 1'b1, 60, 61, 0, {1'b0, {63{1'b1}}}, '1, 0, -1);
    endtask

    task automatic t_restart; // R12
        run_seq("R12", 6, 1, 1'b0, 0, 0, 0, '1, '1, 0, 3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_sub_codes();
        t_group_mask();
        t_twin();
        t_zero_len();
        t_stall();
        t_resume();
        t_clamp();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule